// File: doc/BRIEF.md
# Serial EEPROM SPI Slave Front End

This block sits between a four-wire SPI bus (mode 0) and a 128-byte EEPROM store. It oversamples the bus pins with the system clock. It gathers an 8-bit command and, where the command needs one, an 8-bit address. It then streams bytes out of an internal 128x8 array or repeats the status byte on the serial output. Reads carry on through the whole array for as long as the master keeps clocking, and the pointer wraps at the top.

Commands that change the store are only parsed here. Each completed data byte of a write goes to a separate write controller with its page-wrapped address. The front end also signals a write-enable request and a commit at chip-select release. The write controller feeds back a busy flag and the status byte, and owns the array's write port. A pause input freezes the transfer at any bit and lets it resume later.

Top module: `ee_spi_front`

## Requirements
- R1: Serial input is taken on SCK rising edges only while `cs_n` is low and `hold_n` is high, MSb first. The first 8 bits form the command; commands 03h (read) and 02h (write) take the next 8 bits as the address.
- R2: After a read command and its address, the addressed byte appears on `so` MSb first. Each bit changes after an SCK falling edge. Bit 7 follows the falling edge after the 16th rising edge.
- R3: Further read clocks return the following bytes, with the pointer stepping by one after each byte and wrapping from 7Fh to 00h.
- R4: Bit 7 of the address byte is ignored: address 85h reads location 05h.
- R5: `so_en` is 0 whenever `cs_n` is high or `hold_n` is low, and stays 0 during the command and address bits.
- R6: While `hold_n` is low, SCK edges are ignored. When `hold_n` rises, the transfer continues from the same bit, and SO shows the bit it held before the pause.
- R7: Command 05h drives the `status_in` byte, MSb first, repeated for as long as clocks continue.
- R8: If `wip` is high when a read address completes, `so_en` stays 0 for the rest of that selection. Command 05h still works while `wip` is high.
- R9: Any other command value gives no output and no write-side pulse until `cs_n` rises.
- R10: Command 06h gives a one-cycle `wren_pulse` when `cs_n` rises, but only if exactly 8 bits were clocked.
- R11: After command 02h and its address, each completed data byte gives a one-cycle `wr_valid` with `wr_addr` and `wr_data`. The address steps within its 16-byte page, so the low 4 bits wrap and bits 6:4 stay fixed.
- R12: `wr_commit` pulses once when `cs_n` rises after a write in which at least one data byte was completed and no partial byte followed.
- R13: A cycle with `mem_we` high stores `mem_wdata` at `mem_waddr`, and later reads return the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock, idles low |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause input, active low |
| so | output | 1 | Serial data out value |
| so_en | output | 1 | Output enable for `so`; 0 means high impedance |
| wip | input | 1 | Write cycle in progress, from the write controller |
| status_in | input | 8 | Status byte for command 05h |
| mem_we | input | 1 | Array write strobe |
| mem_waddr | input | 7 | Array write address |
| mem_wdata | input | 8 | Array write data |
| wr_valid | output | 1 | One-cycle strobe for a completed write data byte |
| wr_addr | output | 7 | Page-wrapped address of that byte |
| wr_data | output | 8 | The data byte |
| wren_pulse | output | 1 | Write-enable request, one cycle |
| wr_commit | output | 1 | Write commit request, one cycle |

## Verification
The assertions take for granted that the bus pins change slowly compared with `clk`. Each SCK level must last several system clocks, so the synchronizer sees every edge. They also take for granted that `hold_n` and `cs_n` change only while SCK is low, as mode 0 requires. The stimulus keeps each SCK half period at 8 clocks. It changes SI, HOLD and select only while SCK is low, and it toggles SCK during a pause only to show that those edges are dropped.

// File: rtl/ee_spi_pkg.sv
package ee_spi_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] OP_READ  = 8'h03;
  localparam logic [BYTE_W-1:0] OP_WRITE = 8'h02;
  localparam logic [BYTE_W-1:0] OP_WREN  = 8'h06;
  localparam logic [BYTE_W-1:0] OP_RDSR  = 8'h05;

  typedef enum logic [2:0] {
    PH_OPC, PH_ADDR, PH_RDATA, PH_STAT,
    PH_WADDR, PH_WDATA, PH_WREN, PH_IGNORE
  } phase_e;
endpackage

// File: rtl/ee_spi_sync.sv
module ee_spi_sync #(
  parameter int STAGES = 2,
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic [W-1:0] dprev
);
  logic [W-1:0] pipe [STAGES+1];

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= RST_VAL;
    else     pipe[0] <= din;
  end

  for (genvar g = 1; g <= STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe[g] <= RST_VAL;
      else     pipe[g] <= pipe[g-1];
    end
  end

  assign dout  = pipe[STAGES-1];
  assign dprev = pipe[STAGES];
endmodule

// File: rtl/ee_spi_ram.sv
module ee_spi_ram #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ee_spi_front.sv
module ee_spi_front
  import ee_spi_pkg::*;
#(
  parameter int AW = 7,
  parameter int PAGE_BITS = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              si,
  input  logic              hold_n,
  output logic              so,
  output logic              so_en,
  input  logic              wip,
  input  logic [BYTE_W-1:0] status_in,
  input  logic              mem_we,
  input  logic [AW-1:0]     mem_waddr,
  input  logic [BYTE_W-1:0] mem_wdata,
  output logic              wr_valid,
  output logic [AW-1:0]     wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              wren_pulse,
  output logic              wr_commit
);
  localparam int PB = PAGE_BITS;

  // pin order in the sync vector: {sck, cs_n, si, hold_n}
  logic [3:0] pins_s, pins_p;
  ee_spi_sync #(.STAGES(SYNC_STAGES), .W(4), .RST_VAL(4'b0101)) u_sync (
    .clk(clk), .rst(rst), .din({sck, cs_n, si, hold_n}),
    .dout(pins_s), .dprev(pins_p)
  );

  logic cs_act, cs_rise, hold_act, si_s, rise, fall;
  assign cs_act   = ~pins_s[2];
  assign cs_rise  = pins_s[2] & ~pins_p[2];
  assign si_s     = pins_s[1];
  assign hold_act = pins_s[0];
  assign rise     = pins_s[3] & ~pins_p[3] & cs_act & hold_act;
  assign fall     = ~pins_s[3] & pins_p[3] & cs_act & hold_act;

  phase_e            ph;
  logic [2:0]        bcnt, ocnt;
  logic [BYTE_W-1:0] sr, nb, rdata, txb;
  logic [AW-1:0]     ptr, waddr;
  logic              drv, got, out_ph;

  ee_spi_ram #(.AW(AW), .DW(BYTE_W)) u_ram (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(ptr), .rdata(rdata)
  );

  assign nb     = {sr[BYTE_W-2:0], si_s};
  assign out_ph = (ph == PH_RDATA) || (ph == PH_STAT);
  assign txb    = (ph == PH_STAT) ? status_in : rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= PH_OPC; bcnt <= '0; ocnt <= '0; sr <= '0;
      ptr <= '0; waddr <= '0; drv <= 1'b0; got <= 1'b0;
      so <= 1'b0; so_en <= 1'b0;
      wr_valid <= 1'b0; wr_addr <= '0; wr_data <= '0;
      wren_pulse <= 1'b0; wr_commit <= 1'b0;
    end else begin
      wr_valid   <= 1'b0;
      wren_pulse <= 1'b0;
      wr_commit  <= 1'b0;
      if (cs_rise) begin
        wren_pulse <= (ph == PH_WREN) && (bcnt == 3'd0);
        wr_commit  <= (ph == PH_WDATA) && (bcnt == 3'd0) && got;
      end
      if (!cs_act) begin
        ph <= PH_OPC; bcnt <= '0; ocnt <= '0;
        drv <= 1'b0; got <= 1'b0; so_en <= 1'b0;
      end else begin
        if (rise) begin
          sr   <= nb;
          bcnt <= bcnt + 3'd1;
          if (ph == PH_WREN) ph <= PH_IGNORE;
          else if (bcnt == 3'd7) begin
            unique case (ph)
              PH_OPC: begin
                if      (nb == OP_READ)  ph <= PH_ADDR;
                else if (nb == OP_WRITE) ph <= PH_WADDR;
                else if (nb == OP_WREN)  ph <= PH_WREN;
                else if (nb == OP_RDSR)  ph <= PH_STAT;
                else                     ph <= PH_IGNORE;
              end
              PH_ADDR: begin
                ptr <= nb[AW-1:0];
                ph  <= wip ? PH_IGNORE : PH_RDATA;
              end
              PH_WADDR: begin
                waddr <= nb[AW-1:0];
                ph    <= PH_WDATA;
              end
              PH_WDATA: begin
                wr_valid <= 1'b1;
                wr_addr  <= waddr;
                wr_data  <= nb;
                got      <= 1'b1;
                waddr    <= {waddr[AW-1:PB], PB'(waddr[PB-1:0] + 1'b1)};
              end
              default: ;
            endcase
          end
        end
        if (fall && out_ph) begin
          so   <= txb[~ocnt];
          drv  <= 1'b1;
          ocnt <= ocnt + 3'd1;
          if (ocnt == 3'd7 && ph == PH_RDATA) ptr <= ptr + 1'b1;
        end
        so_en <= (drv | (fall & out_ph)) & hold_act;
      end
    end
  end

  // ---------------- assertions ----------------
  p_so_off_cs_r5: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !so_en);
  p_so_off_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !hold_act |=> !so_en);
  p_frozen_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (cs_act && !hold_act) |=> ($stable(bcnt) && $stable(ocnt) && $stable(so)));
  p_ptr_step_r3: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_RDATA && $past(ph) == PH_RDATA) |->
      (ptr == $past(ptr) || ptr == $past(ptr) + 1'b1));
  p_page_fixed_r11: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_WDATA && $past(ph) == PH_WDATA) |->
      (waddr[AW-1:PB] == $past(waddr[AW-1:PB])));
  p_busy_no_read_r8: assert property (@(posedge clk) disable iff (rst)
    (rise && ph == PH_ADDR && bcnt == 3'd7 && wip) |=> (ph != PH_RDATA));
  p_wren_at_cs_r10: assert property (@(posedge clk) disable iff (rst)
    wren_pulse |-> $past(cs_rise));
  p_commit_at_cs_r12: assert property (@(posedge clk) disable iff (rst)
    wr_commit |-> $past(cs_rise));
  p_ignore_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_IGNORE) |-> !wr_valid);
endmodule

// File: tb/ee_spi_front_bench.sv
module ee_spi_front_bench;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1;
  logic so, so_en, wip = 1'b0;
  logic [7:0] status_in = 8'h00;
  logic mem_we = 1'b0;
  logic [6:0] mem_waddr = '0;
  logic [7:0] mem_wdata = '0;
  logic wr_valid, wren_pulse, wr_commit;
  logic [6:0] wr_addr;
  logic [7:0] wr_data;

  always #4 clk = ~clk;

  ee_spi_front u_ee_spi_front (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
    .so(so), .so_en(so_en), .wip(wip), .status_in(status_in),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .wren_pulse(wren_pulse), .wr_commit(wr_commit)
  );

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  int model [128];
  int qa[$], qd[$];
  int n_wren = 0, n_commit = 0;
  bit en_seen = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (wr_valid) begin qa.push_back(int'(wr_addr)); qd.push_back(int'(wr_data)); end
      if (wren_pulse) n_wren++;
      if (wr_commit) n_commit++;
      if (so_en) en_seen = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_events();
    qa.delete(); qd.delete(); n_wren = 0; n_commit = 0; en_seen = 1'b0;
  endtask

  task automatic bit_x(input logic sv, output logic ov, output logic ev);
    si = sv;
    repeat (HALF) @(negedge clk);
    ov = so; ev = so_en;
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic byte_x(input logic [7:0] tx, output logic [7:0] rx, output logic [7:0] en);
    for (int i = 7; i >= 0; i--) bit_x(tx[i], rx[i], en[i]);
  endtask

  task automatic sel();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic desel();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic mem_put(input int a, input int d);
    @(negedge clk);
    mem_we = 1'b1; mem_waddr = 7'(a); mem_wdata = 8'(d);
    @(negedge clk);
    mem_we = 1'b0;
    model[a] = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx, en;
    logic b, e;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(so_en == 1'b0 && wr_valid == 1'b0 && wren_pulse == 1'b0, "R5 reset", int'(so_en), 0);

    for (int a = 0; a < 128; a++) mem_put(a, (a * 37 + 11) & 8'hFF);

    // R1 R2 R5: plain read
    clear_events();
    sel();
    byte_x(8'h03, rx, en); chk(en == 8'h00, "R5 cmd bits", int'(en), 0);
    byte_x(8'h10, rx, en); chk(en == 8'h00, "R5 addr bits", int'(en), 0);
    byte_x(8'h00, rx, en);
    chk(en == 8'hFF && rx == 8'(model[16]), "R2 first byte", int'(rx), model[16]);
    chk(en == 8'hFF && rx == 8'(model[16]), "R1 msb first", int'(rx), model[16]);
    byte_x(8'h00, rx, en);
    chk(rx == 8'(model[17]), "R3 next byte", int'(rx), model[17]);
    desel();
    chk(so_en == 1'b0, "R5 cs high", int'(so_en), 0);

    // R3 wrap, R4 upper address bit
    sel();
    byte_x(8'h03, rx, en); byte_x(8'hFE, rx, en);
    byte_x(8'h00, rx, en); chk(rx == 8'(model[126]), "R4 bit7 ignored", int'(rx), model[126]);
    byte_x(8'h00, rx, en); chk(rx == 8'(model[127]), "R3 top byte", int'(rx), model[127]);
    byte_x(8'h00, rx, en); chk(rx == 8'(model[0]), "R3 wrap to 0", int'(rx), model[0]);
    desel();
    sel();
    byte_x(8'h03, rx, en); byte_x(8'h85, rx, en);
    byte_x(8'h00, rx, en); chk(rx == 8'(model[5]), "R4 addr 85h", int'(rx), model[5]);
    desel();

    // R6 pause mid-byte
    sel();
    byte_x(8'h03, rx, en); byte_x(8'h20, rx, en);
    byte_x(8'h00, rx, en); chk(rx == 8'(model[32]), "R6 pre-pause", int'(rx), model[32]);
    for (int i = 7; i >= 5; i--) begin bit_x(1'b0, b, e); rx[i] = b; end
    hold_n = 1'b0;
    repeat (6) @(negedge clk);
    chk(so_en == 1'b0, "R5 hold low", int'(so_en), 0);
    for (int k = 0; k < 3; k++) begin
      repeat (HALF) @(negedge clk); sck = 1'b1;
      repeat (HALF) @(negedge clk); sck = 1'b0;
    end
    chk(so_en == 1'b0, "R6 paused", int'(so_en), 0);
    hold_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(so_en == 1'b1, "R6 resumed enable", int'(so_en), 1);
    for (int i = 4; i >= 0; i--) begin bit_x(1'b0, b, e); rx[i] = b; end
    chk(rx == 8'(model[33]), "R6 resumed data", int'(rx), model[33]);
    desel();

    // R7 R8 status and busy
    status_in = 8'hA5;
    sel();
    byte_x(8'h05, rx, en);
    byte_x(8'h00, rx, en); chk(rx == 8'hA5 && en == 8'hFF, "R7 status", int'(rx), 'hA5);
    byte_x(8'h00, rx, en); chk(rx == 8'hA5, "R7 status repeat", int'(rx), 'hA5);
    desel();
    wip = 1'b1;
    clear_events();
    sel();
    byte_x(8'h03, rx, en); byte_x(8'h10, rx, en);
    byte_x(8'h00, rx, en); byte_x(8'h00, rx, en);
    desel();
    chk(en_seen == 1'b0, "R8 busy read", int'(en_seen), 0);
    status_in = 8'h03;
    sel();
    byte_x(8'h05, rx, en);
    byte_x(8'h00, rx, en); chk(rx == 8'h03 && en == 8'hFF, "R8 status while busy", int'(rx), 3);
    desel();
    wip = 1'b0;

    // R9 unknown command
    clear_events();
    sel();
    byte_x(8'hAB, rx, en); byte_x(8'h03, rx, en); byte_x(8'h06, rx, en);
    desel();
    chk(en_seen == 1'b0 && qa.size() == 0 && n_wren == 0 && n_commit == 0,
        "R9 unknown", int'(en_seen) + qa.size() + n_wren + n_commit, 0);

    // R10 enable request
    clear_events();
    sel(); byte_x(8'h06, rx, en); desel();
    chk(n_wren == 1, "R10 wren exact", n_wren, 1);
    clear_events();
    sel(); byte_x(8'h06, rx, en); bit_x(1'b0, b, e); desel();
    chk(n_wren == 0, "R10 wren extra bit", n_wren, 0);

    // R11 R12 page write with wrap
    clear_events();
    sel();
    byte_x(8'h02, rx, en); byte_x(8'h1E, rx, en);
    byte_x(8'h11, rx, en); byte_x(8'h22, rx, en);
    byte_x(8'h33, rx, en); byte_x(8'h44, rx, en);
    desel();
    chk(qa.size() == 4, "R11 byte count", qa.size(), 4);
    if (qa.size() == 4) begin
      chk(qa[0] == 'h1E && qd[0] == 'h11, "R11 byte0", qa[0], 'h1E);
      chk(qa[1] == 'h1F && qd[1] == 'h22, "R11 byte1", qa[1], 'h1F);
      chk(qa[2] == 'h10 && qd[2] == 'h33, "R11 page wrap", qa[2], 'h10);
      chk(qa[3] == 'h11 && qd[3] == 'h44, "R11 byte3", qa[3], 'h11);
    end
    chk(n_commit == 1, "R12 commit", n_commit, 1);
    clear_events();
    sel();
    byte_x(8'h02, rx, en); byte_x(8'h20, rx, en); byte_x(8'h5A, rx, en);
    for (int i = 0; i < 4; i++) bit_x(1'b1, b, e);
    desel();
    chk(qa.size() == 1, "R11 partial", qa.size(), 1);
    chk(n_commit == 0, "R12 partial no commit", n_commit, 0);
    clear_events();
    sel(); byte_x(8'h02, rx, en); byte_x(8'h20, rx, en); desel();
    chk(n_commit == 0, "R12 no data no commit", n_commit, 0);

    // R13 array write port
    mem_put(64, 8'hC3);
    sel();
    byte_x(8'h03, rx, en); byte_x(8'h40, rx, en);
    byte_x(8'h00, rx, en); chk(rx == 8'hC3, "R13 store", int'(rx), 'hC3);
    desel();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule